// File: doc/BRIEF.md
# Command Header Length Decoder

This block inspects a single 32-bit header word from a graphics command stream and reports, for that word, whether it is an acceptable header, how many 32-bit words the complete command spans (header counted), and whether the word is one of the two batch markers: the word that closes a batch or the word that opens one. A stream walker feeds it each header it reaches. The walker then uses the reported length to find the next header, and uses the marker flags to follow or leave a batch.

Decoding is purely combinational. A parameter selects whether a register stage sits after that logic. There is no handshake: a word presented on the input yields its results either in the same cycle or one clock later. The sets of defined opcodes are held as parameter bitmaps, with one bit per opcode, and the commands that occupy a single word are held as a parameter list of keys.

Top module: `cmdhdr_len_dec`

## Requirements
- R1: With REG_OUT=1 (the default), every output is zero while rst_n is low. After reset, the results for the word sampled at a rising clock edge appear on the outputs from that edge onward.
- R2: Bits 31:29 select the class. Classes 4 to 7 (bit 31 set) are reported invalid with a length of 0.
- R3: A class 1 word (bits 31:29 = 3'b001) is reported valid with a length of 0.
- R4: Class 0 (memory-interface) takes its opcode from bits 28:23. An opcode below 0x10 gives a length of 1. Any other opcode gives a length of bits 5:0 plus 2.
- R5: A class 0 word with opcode 0 is valid only when the whole word is 0x00000000. Any other such word is invalid with a length of 0.
- R6: Only these class 0 opcodes are defined: 0x00–0x05, 0x07, 0x0A, 0x11–0x14, 0x18, 0x20–0x22, 0x24 and 0x31. Any other opcode is invalid with a length of 0.
- R7: Class 2 (2D) takes its opcode from bits 28:22 and gives a length of bits 4:0 plus 2. Only these opcodes are defined: 0x01, 0x03, 0x11, 0x24–0x26, 0x31, 0x40, 0x43, 0x50–0x59 and 0x71–0x77. Any other opcode is invalid with a length of 0.
- R8: Class 3 (3D/media) is always valid, whatever its sub-pipeline (bits 28:27), opcode (bits 26:24) and sub-opcode (bits 23:16). Its length is bits 7:0 plus 2.
- R9: Two class 3 headers are single-word and have a length of 1 whatever bits 7:0 hold: sub-pipeline 0 with opcode 1 and sub-opcode 0x04, and sub-pipeline 3 with opcode 0 and sub-opcode 0x0B. Sub-pipeline 1 with opcode 1 and sub-opcode 0x04 is not single-word.
- R10: The batch-end flag is set only for the word 0x05000000 exactly.
- R11: The batch-start flag is set when (word & 0xFFFFF8FF) == 0x18800080. Bits 10:8 are free; every other bit is fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_i | input | 32 | Header word to decode |
| ok_o | output | 1 | Header is acceptable |
| len_o | output | 9 | Total command length in 32-bit words |
| batch_end_o | output | 1 | Word closes a batch |
| batch_start_o | output | 1 | Word opens a batch |

## Verification
With the default registered stage, each result is due at the first rising edge after the word is driven and stays valid until the following edge. The bench drives each word on a falling edge and reads all four outputs on the next falling edge, half a period after the capturing edge. The assertions compare each output against the input word one cycle back. The reset check reads the outputs while rst_n is still low, with a nonzero word on the input.

// File: rtl/cmdhdr_pkg.sv
package cmdhdr_pkg;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 9;
    localparam int KEY_W   = 13;

    typedef enum logic [2:0] {
        CLS_MEM   = 3'd0,
        CLS_NOLEN = 3'd1,
        CLS_BLT   = 3'd2,
        CLS_PIPE  = 3'd3
    } cls_e;

    typedef struct packed {
        logic             ok;
        logic [LEN_W-1:0] len;
    } dec_res_t;
endpackage

// File: rtl/cmdhdr_mem_dec.sv
module cmdhdr_mem_dec
    import cmdhdr_pkg::*;
#(
    parameter logic [63:0] DEFINED = 64'h0002_0017_011E_04BF
) (
    input  logic [WORD_W-1:0] hdr,
    output dec_res_t          res
);
    logic [5:0] op;
    logic       known;
    logic       zero_rule;

    always_comb begin
        op        = hdr[28:23];
        known     = DEFINED[op];
        zero_rule = (op != 6'd0) || (hdr == '0);
        res.ok    = known && zero_rule;
        if (!res.ok)
            res.len = '0;
        else if (op < 6'h10)
            res.len = LEN_W'(1);
        else
            res.len = LEN_W'(hdr[5:0]) + LEN_W'(2);
    end
endmodule

// File: rtl/cmdhdr_blt_dec.sv
module cmdhdr_blt_dec
    import cmdhdr_pkg::*;
#(
    parameter logic [127:0] DEFINED = 128'h00FE_0000_03FF_0009_0002_0070_0002_000A
) (
    input  logic [WORD_W-1:0] hdr,
    output dec_res_t          res
);
    logic [6:0] op;

    always_comb begin
        op      = hdr[28:22];
        res.ok  = DEFINED[op];
        res.len = res.ok ? (LEN_W'(hdr[4:0]) + LEN_W'(2)) : '0;
    end
endmodule

// File: rtl/cmdhdr_pipe_dec.sv
module cmdhdr_pipe_dec
    import cmdhdr_pkg::*;
#(
    parameter int                        N_ONE = 2,
    parameter logic [N_ONE*KEY_W-1:0]    ONE_KEYS = {13'h180B, 13'h0104}
) (
    input  logic [WORD_W-1:0] hdr,
    output dec_res_t          res
);
    logic [KEY_W-1:0] key;
    logic [N_ONE-1:0] hit;

    assign key = hdr[28:16];

    for (genvar k = 0; k < N_ONE; k++) begin : g_key
        assign hit[k] = (key == ONE_KEYS[k*KEY_W +: KEY_W]);
    end

    always_comb begin
        res.ok  = 1'b1;
        res.len = (|hit) ? LEN_W'(1) : (LEN_W'(hdr[7:0]) + LEN_W'(2));
    end
endmodule

// File: rtl/cmdhdr_marker.sv
module cmdhdr_marker
    import cmdhdr_pkg::*;
#(
    parameter logic [WORD_W-1:0] END_WORD   = 32'h0500_0000,
    parameter logic [WORD_W-1:0] START_MASK = 32'hFFFF_F8FF,
    parameter logic [WORD_W-1:0] START_PAT  = 32'h1880_0080
) (
    input  logic [WORD_W-1:0] hdr,
    output logic              is_end,
    output logic              is_start
);
    assign is_end   = (hdr == END_WORD);
    assign is_start = ((hdr & START_MASK) == START_PAT);
endmodule

// File: rtl/cmdhdr_len_dec.sv
module cmdhdr_len_dec
    import cmdhdr_pkg::*;
#(
    parameter bit           REG_OUT     = 1'b1,
    parameter logic [63:0]  MEM_DEFINED = 64'h0002_0017_011E_04BF,
    parameter logic [127:0] BLT_DEFINED = 128'h00FE_0000_03FF_0009_0002_0070_0002_000A,
    parameter int           N_ONE       = 2,
    parameter logic [N_ONE*KEY_W-1:0] ONE_KEYS = {13'h180B, 13'h0104}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       hdr_i,
    output logic              ok_o,
    output logic [8:0]        len_o,
    output logic              batch_end_o,
    output logic              batch_start_o
);
    dec_res_t mem_res, blt_res, pipe_res, sel_res;
    logic     end_c, start_c;
    cls_e     cls;

    cmdhdr_mem_dec #(.DEFINED(MEM_DEFINED)) u_mem (.hdr(hdr_i), .res(mem_res));
    cmdhdr_blt_dec #(.DEFINED(BLT_DEFINED)) u_blt (.hdr(hdr_i), .res(blt_res));
    cmdhdr_pipe_dec #(.N_ONE(N_ONE), .ONE_KEYS(ONE_KEYS)) u_pipe (.hdr(hdr_i), .res(pipe_res));
    cmdhdr_marker u_mark (.hdr(hdr_i), .is_end(end_c), .is_start(start_c));

    always_comb begin
        cls = cls_e'(hdr_i[31:29]);
        sel_res = '0;
        unique case (hdr_i[31:29])
            CLS_MEM:   sel_res = mem_res;
            CLS_NOLEN: sel_res = '{ok: 1'b1, len: '0};
            CLS_BLT:   sel_res = blt_res;
            CLS_PIPE:  sel_res = pipe_res;
            default:   sel_res = '0;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ok_o          <= 1'b0;
                    len_o         <= '0;
                    batch_end_o   <= 1'b0;
                    batch_start_o <= 1'b0;
                end else begin
                    ok_o          <= sel_res.ok;
                    len_o         <= sel_res.len;
                    batch_end_o   <= end_c;
                    batch_start_o <= start_c;
                end
            end

            a_r2_high_class_bad: assert property (@(posedge clk) disable iff (!rst_n)
                hdr_i[31] |=> (!ok_o && len_o == '0));
            a_r3_class1_zero: assert property (@(posedge clk) disable iff (!rst_n)
                (hdr_i[31:29] == 3'd1) |=> (ok_o && len_o == '0));
            a_r9_single_word: assert property (@(posedge clk) disable iff (!rst_n)
                (hdr_i[31:29] == 3'd3 && hdr_i[28:16] == 13'h0104) |=> (len_o == 9'd1));
            a_r11_start_len: assert property (@(posedge clk) disable iff (!rst_n)
                batch_start_o |-> (ok_o && len_o == 9'($past(hdr_i[5:0])) + 9'd2));
            a_r10_marker_excl: assert property (@(posedge clk) disable iff (!rst_n)
                !(batch_end_o && batch_start_o));
            a_r5_bad_no_len: assert property (@(posedge clk) disable iff (!rst_n)
                !ok_o |-> (len_o == '0));
        end else begin : g_comb
            assign ok_o          = sel_res.ok;
            assign len_o         = sel_res.len;
            assign batch_end_o   = end_c;
            assign batch_start_o = start_c;

            a_r10_end_is_mem: assert property (@(posedge clk) disable iff (!rst_n)
                batch_end_o |-> (ok_o && len_o == 9'd1));
        end
    endgenerate

    logic unused_cls;
    assign unused_cls = ^cls;
endmodule

// File: tb/sim_cmdhdr_len_dec.sv
module sim_cmdhdr_len_dec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hdr_i = 32'h0;
    logic        ok_o, batch_end_o, batch_start_o;
    logic [8:0]  len_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    cmdhdr_len_dec u0 (
        .clk(clk), .rst_n(rst_n), .hdr_i(hdr_i),
        .ok_o(ok_o), .len_o(len_o),
        .batch_end_o(batch_end_o), .batch_start_o(batch_start_o)
    );

    task automatic check(string req, logic [31:0] w, logic e_ok, logic [8:0] e_len,
                         logic e_end, logic e_start);
        total++;
        if (ok_o !== e_ok || len_o !== e_len || batch_end_o !== e_end ||
            batch_start_o !== e_start) begin
            bad++;
            $display("FAIL %s word=%08h actual ok=%0b len=%0d end=%0b start=%0b expected ok=%0b len=%0d end=%0b start=%0b",
                     req, w, ok_o, len_o, batch_end_o, batch_start_o,
                     e_ok, e_len, e_end, e_start);
        end
    endtask

    task automatic apply(string req, logic [31:0] w, logic e_ok, logic [8:0] e_len,
                         logic e_end, logic e_start);
        @(negedge clk);
        hdr_i = w;
        @(negedge clk);
        check(req, w, e_ok, e_len, e_end, e_start);
    endtask

    task automatic t_reset;
        hdr_i = 32'h7877_00FF;
        repeat (3) @(negedge clk);
        check("R1", hdr_i, 1'b0, 9'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", hdr_i, 1'b1, 9'd257, 1'b0, 1'b0);
    endtask

    task automatic t_classes;
        apply("R2", 32'h8000_0000, 1'b0, 9'd0, 1'b0, 1'b0);
        apply("R2", 32'hE3FF_FFFF, 1'b0, 9'd0, 1'b0, 1'b0);
        apply("R3", 32'h2ABC_DEF7, 1'b1, 9'd0, 1'b0, 1'b0);
    endtask

    task automatic t_mem;
        apply("R4", 32'h0200_003F, 1'b1, 9'd1, 1'b0, 1'b0);
        apply("R4", 32'h1000_003F, 1'b1, 9'd65, 1'b0, 1'b0);
        apply("R4", 32'h0900_0003, 1'b1, 9'd5, 1'b0, 1'b0);
        apply("R5", 32'h0000_0000, 1'b1, 9'd1, 1'b0, 1'b0);
        apply("R5", 32'h0000_0001, 1'b0, 9'd0, 1'b0, 1'b0);
        apply("R6", 32'h0300_0000, 1'b0, 9'd0, 1'b0, 1'b0);
        apply("R6", 32'h1180_0004, 1'b0, 9'd0, 1'b0, 1'b0);
    endtask

    task automatic t_blt;
        apply("R7", 32'h54C0_0006, 1'b1, 9'd8, 1'b0, 1'b0);
        apply("R7", 32'h5DC0_001F, 1'b1, 9'd33, 1'b0, 1'b0);
        apply("R7", 32'h4000_0000, 1'b0, 9'd0, 1'b0, 1'b0);
        apply("R7", 32'h5E80_0001, 1'b0, 9'd0, 1'b0, 1'b0);
    endtask

    task automatic t_pipe;
        apply("R8", 32'h7877_00FF, 1'b1, 9'd257, 1'b0, 1'b0);
        apply("R8", 32'h6000_0000, 1'b1, 9'd2, 1'b0, 1'b0);
        apply("R9", 32'h6104_0005, 1'b1, 9'd1, 1'b0, 1'b0);
        apply("R9", 32'h780B_0007, 1'b1, 9'd1, 1'b0, 1'b0);
        apply("R9", 32'h6904_0003, 1'b1, 9'd5, 1'b0, 1'b0);
    endtask

    task automatic t_markers;
        apply("R10", 32'h0500_0000, 1'b1, 9'd1, 1'b1, 1'b0);
        apply("R10", 32'h0500_0001, 1'b1, 9'd1, 1'b0, 1'b0);
        apply("R11", 32'h1880_0380, 1'b1, 9'd2, 1'b0, 1'b1);
        apply("R11", 32'h1880_0081, 1'b1, 9'd3, 1'b0, 1'b0);
        apply("R11", 32'h1880_00C0, 1'b1, 9'd2, 1'b0, 1'b0);
        apply("R11", 32'h1880_1080, 1'b1, 9'd2, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_classes();
        t_mem();
        t_blt();
        t_pipe();
        t_markers();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule